// File: doc/BRIEF.md
# Split-Transaction OUT Payload Sequencer

This block cuts one full-speed isochronous OUT transfer into the series of start-split payloads that a high-speed host sends toward a transaction translator. Software loads a transfer once. The load gives two 4 KB buffer page frames, a starting page selector, a byte offset inside the selected page, a total byte length, the initial position code, a start-split count and a link terminate bit. The block then offers one payload descriptor at a time on a valid/ready handshake. Each descriptor holds a 32-bit byte address, a byte count and a 2-bit position tag.

After every accepted descriptor the block updates its own state. The offset moves forward by the slice length, the count drops by one, and the position tag moves on. When the offset runs past the end of page 0, the page selector flips to page 1. The transfer retires with a one-cycle done pulse. In that cycle the block also reports whether the back link is valid. Illegal counts and a buffer that runs past page 1 are reported on error flags instead.

Top module: `splitOutSeq`

## Requirements
- R1: A load with count 1 produces exactly one descriptor. It carries the whole loaded length and the loaded position code (software loads 00 = all for a payload of 188 bytes or less). Done follows its handshake.
- R2: With a count above 1, the first descriptor carries the loaded code (01 = begin). Each later descriptor is tagged 10 (mid), except the one issued when one slice remains, which is tagged 11 (end).
- R3: A load with count 0 or above 6 sets errCount in the next cycle. It issues no descriptor and leaves busy low. The next accepted load clears errCount.
- R4: Every descriptor before the last carries 188 bytes, or the remaining length if that is smaller. The last descriptor carries all remaining bytes.
- R5: sliceAddr is {selected page frame, current offset}. Bits 31:12 come from page 0 when the selector is 0 and from page 1 when it is 1. Bits 11:0 are the current offset.
- R6: After each handshake the offset advances by the slice byte count. If this reaches 4096 or more on page 0, the selector flips to 1 and the offset wraps modulo 4096.
- R7: A handshake whose slice ends beyond byte 4096 of page 1 sets errOverflow in the next cycle. It also stops the sequence: busy and sliceValid drop, and no done pulse follows.
- R8: sliceValid is high exactly while a transfer runs. While sliceReady is low, sliceAddr, sliceBytes and slicePos hold steady.
- R9: done pulses for one cycle, in the cycle after the final handshake. backLinkValid is high only in that cycle, and only when the loaded terminate bit was 0.
- R10: loadValid is ignored while busy is high. A synchronous reset clears busy, sliceValid, done and both error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loadValid | input | 1 | Load request, taken only when idle |
| loadPage0 | input | 20 | Page 0 frame, address bits 31:12 |
| loadPage1 | input | 20 | Page 1 frame, address bits 31:12 |
| loadOffset | input | 12 | Starting byte offset in the selected page |
| loadPageSel | input | 1 | Starting page selector |
| loadLength | input | LEN_W | Total payload bytes |
| loadPos | input | 2 | Initial position code |
| loadCount | input | 3 | Number of start-splits, legal 1..6 |
| loadLinkTerm | input | 1 | 1 = back link invalid |
| busy | output | 1 | Transfer in progress |
| sliceValid | output | 1 | Descriptor offered |
| sliceReady | input | 1 | Descriptor accepted when high with sliceValid |
| sliceAddr | output | 32 | Byte address of the slice |
| sliceBytes | output | LEN_W | Byte count of the slice |
| slicePos | output | 2 | Position tag: 00 all, 01 begin, 10 mid, 11 end |
| done | output | 1 | One-cycle retire pulse |
| backLinkValid | output | 1 | Back link valid, qualified by done |
| errCount | output | 1 | Illegal count was loaded |
| errOverflow | output | 1 | Buffer ran past page 1 |

## Verification
Two things can happen in the same handshake: a page flip and the move to the end tag. The bench provokes this by starting a two-slice transfer 128 bytes before the end of page 0. The second descriptor must then show both the page 1 frame and tag 11. A variant starts the first slice so that it ends exactly on the page boundary; it must give offset 0 in page 1. A load request is also raised during a stalled handshake, in the same cycles as a live descriptor. It is judged by checking that every descriptor field stays as it was and that the sequence goes on unchanged.

// File: rtl/spoSeqPkg.sv
package spoSeqPkg;
  localparam int SLICE_BYTES = 188;
  localparam int PAGE_BYTES  = 4096;
  localparam int MAX_COUNT   = 6;
  localparam int CNT_W       = 3;

  typedef enum logic [1:0] {
    POS_ALL   = 2'b00,
    POS_BEGIN = 2'b01,
    POS_MID   = 2'b10,
    POS_END   = 2'b11
  } posCode_e;

  typedef struct packed {
    logic load;
    logic advance;
  } spoStrobe_t;
endpackage

// File: rtl/spoSeqDatapath.sv
module spoSeqDatapath
  import spoSeqPkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  spoStrobe_t        strobe,
  input  logic [19:0]       loadPage0,
  input  logic [19:0]       loadPage1,
  input  logic [11:0]       loadOffset,
  input  logic              loadPageSel,
  input  logic [LEN_W-1:0]  loadLength,
  input  logic [1:0]        loadPos,
  input  logic [CNT_W-1:0]  loadCount,
  input  logic              loadLinkTerm,
  output logic [31:0]       sliceAddr,
  output logic [LEN_W-1:0]  sliceBytes,
  output logic [1:0]        slicePos,
  output logic              lastSlice,
  output logic              overflowHit,
  output logic              linkTerm
);
  localparam int SUM_W = ((LEN_W > 12) ? LEN_W : 12) + 2;
  localparam logic [LEN_W-1:0] SLICE_LEN = LEN_W'(SLICE_BYTES);

  logic [19:0]      page0Q, page1Q;
  logic [11:0]      offQ;
  logic             selQ;
  logic [LEN_W-1:0] remQ;
  logic [CNT_W-1:0] cntQ;
  posCode_e         posQ;
  logic             termQ;
  logic [SUM_W-1:0] endSum;
  logic             crossPage;

  always_comb begin
    if (cntQ == CNT_W'(1))      sliceBytes = remQ;
    else if (remQ > SLICE_LEN)  sliceBytes = SLICE_LEN;
    else                        sliceBytes = remQ;
  end

  assign lastSlice   = (cntQ == CNT_W'(1));
  assign endSum      = SUM_W'(offQ) + SUM_W'(sliceBytes);
  assign crossPage   = !selQ && (endSum >= SUM_W'(PAGE_BYTES))
                       && (endSum <= SUM_W'(2 * PAGE_BYTES));
  assign overflowHit = selQ ? (endSum > SUM_W'(PAGE_BYTES))
                            : (endSum > SUM_W'(2 * PAGE_BYTES));
  assign sliceAddr   = {(selQ ? page1Q : page0Q), offQ};
  assign slicePos    = posQ;
  assign linkTerm    = termQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      page0Q <= '0;
      page1Q <= '0;
      offQ   <= '0;
      selQ   <= 1'b0;
      remQ   <= '0;
      cntQ   <= '0;
      posQ   <= POS_ALL;
      termQ  <= 1'b1;
    end else if (strobe.load) begin
      page0Q <= loadPage0;
      page1Q <= loadPage1;
      offQ   <= loadOffset;
      selQ   <= loadPageSel;
      remQ   <= loadLength;
      cntQ   <= loadCount;
      posQ   <= posCode_e'(loadPos);
      termQ  <= loadLinkTerm;
    end else if (strobe.advance) begin
      offQ <= endSum[11:0];
      if (crossPage) selQ <= 1'b1;
      remQ <= remQ - sliceBytes;
      cntQ <= cntQ - CNT_W'(1);
      posQ <= (cntQ == CNT_W'(2)) ? POS_END : POS_MID;
    end
  end
endmodule

// File: rtl/spoSeqControl.sv
module spoSeqControl
  import spoSeqPkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             loadValid,
  input  logic [CNT_W-1:0] loadCount,
  input  logic             sliceReady,
  input  logic             lastSlice,
  input  logic             overflowHit,
  output spoStrobe_t       strobe,
  output logic             busy,
  output logic             done,
  output logic             errCount,
  output logic             errOverflow
);
  logic runQ, doneQ, errCntQ, errOvfQ;
  logic countOk, fire;

  assign countOk        = (loadCount != '0) && (loadCount <= CNT_W'(MAX_COUNT));
  assign fire           = runQ && sliceReady;
  assign strobe.load    = !runQ && loadValid && countOk;
  assign strobe.advance = fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      runQ    <= 1'b0;
      doneQ   <= 1'b0;
      errCntQ <= 1'b0;
      errOvfQ <= 1'b0;
    end else begin
      doneQ <= fire && lastSlice && !overflowHit;
      if (strobe.load) begin
        runQ    <= 1'b1;
        errCntQ <= 1'b0;
        errOvfQ <= 1'b0;
      end else if (!runQ && loadValid) begin
        errCntQ <= 1'b1;
      end
      if (fire && (lastSlice || overflowHit)) runQ <= 1'b0;
      if (fire && overflowHit) errOvfQ <= 1'b1;
    end
  end

  assign busy        = runQ;
  assign done        = doneQ;
  assign errCount    = errCntQ;
  assign errOverflow = errOvfQ;
endmodule

// File: rtl/splitOutSeq.sv
module splitOutSeq
  import spoSeqPkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadValid,
  input  logic [19:0]       loadPage0,
  input  logic [19:0]       loadPage1,
  input  logic [11:0]       loadOffset,
  input  logic              loadPageSel,
  input  logic [LEN_W-1:0]  loadLength,
  input  logic [1:0]        loadPos,
  input  logic [2:0]        loadCount,
  input  logic              loadLinkTerm,
  output logic              busy,
  output logic              sliceValid,
  input  logic              sliceReady,
  output logic [31:0]       sliceAddr,
  output logic [LEN_W-1:0]  sliceBytes,
  output logic [1:0]        slicePos,
  output logic              done,
  output logic              backLinkValid,
  output logic              errCount,
  output logic              errOverflow
);
  spoStrobe_t strobe;
  logic lastSlice, overflowHit, linkTerm;

  spoSeqControl uCtrl (
    .clk(clk), .rst(rst), .loadValid(loadValid), .loadCount(loadCount),
    .sliceReady(sliceReady), .lastSlice(lastSlice), .overflowHit(overflowHit),
    .strobe(strobe), .busy(busy), .done(done), .errCount(errCount),
    .errOverflow(errOverflow)
  );

  spoSeqDatapath #(.LEN_W(LEN_W)) uData (
    .clk(clk), .rst(rst), .strobe(strobe), .loadPage0(loadPage0),
    .loadPage1(loadPage1), .loadOffset(loadOffset), .loadPageSel(loadPageSel),
    .loadLength(loadLength), .loadPos(loadPos), .loadCount(loadCount),
    .loadLinkTerm(loadLinkTerm), .sliceAddr(sliceAddr), .sliceBytes(sliceBytes),
    .slicePos(slicePos), .lastSlice(lastSlice), .overflowHit(overflowHit),
    .linkTerm(linkTerm)
  );

  assign sliceValid    = busy;
  assign backLinkValid = done && !linkTerm;
endmodule

// File: rtl/spoSeqChecker.sv
module spoSeqChecker #(
  parameter int LEN_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             loadValid,
  input logic [2:0]       loadCount,
  input logic             busy,
  input logic             sliceValid,
  input logic             sliceReady,
  input logic [31:0]      sliceAddr,
  input logic [LEN_W-1:0] sliceBytes,
  input logic [1:0]       slicePos,
  input logic             done,
  input logic             backLinkValid,
  input logic             errCount,
  input logic             errOverflow
);
  p_bad_count_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy && loadValid && (loadCount == 3'd0 || loadCount > 3'd6))
      |=> (errCount && !sliceValid && !busy));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (sliceValid && !sliceReady)
      |=> (sliceValid && $stable(sliceAddr) && $stable(sliceBytes) && $stable(slicePos)));

  p_begin_moves_on_r2: assert property (@(posedge clk) disable iff (rst)
    (sliceValid && sliceReady && slicePos == 2'b01)
      |=> (errOverflow || !sliceValid || slicePos == 2'b10 || slicePos == 2'b11));

  p_no_overflow_done_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(errOverflow) |-> (!done && !busy));

  p_done_after_fire_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(sliceValid && sliceReady));

  p_link_in_done_r9: assert property (@(posedge clk) disable iff (rst)
    backLinkValid |-> done);

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind splitOutSeq spoSeqChecker #(.LEN_W(LEN_W)) uChk (
  .clk(clk), .rst(rst), .loadValid(loadValid), .loadCount(loadCount),
  .busy(busy), .sliceValid(sliceValid), .sliceReady(sliceReady),
  .sliceAddr(sliceAddr), .sliceBytes(sliceBytes), .slicePos(slicePos),
  .done(done), .backLinkValid(backLinkValid), .errCount(errCount),
  .errOverflow(errOverflow)
);

// File: tb/tb_splitOutSeq.sv
`timescale 1ns/1ps
module tb_splitOutSeq;
  localparam int LEN_W = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic loadValid = 1'b0;
  logic [19:0] loadPage0 = '0, loadPage1 = '0;
  logic [11:0] loadOffset = '0;
  logic loadPageSel = 1'b0;
  logic [LEN_W-1:0] loadLength = '0;
  logic [1:0] loadPos = '0;
  logic [2:0] loadCount = '0;
  logic loadLinkTerm = 1'b1;
  logic sliceReady = 1'b0;
  logic busy, sliceValid, done, backLinkValid, errCount, errOverflow;
  logic [31:0] sliceAddr;
  logic [LEN_W-1:0] sliceBytes;
  logic [1:0] slicePos;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  splitOutSeq #(.LEN_W(LEN_W)) dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic doLoad(input logic [19:0] p0, input logic [19:0] p1,
                        input logic [11:0] off, input logic sel,
                        input int len, input logic [1:0] pos,
                        input logic [2:0] cnt, input logic term);
    loadPage0 = p0; loadPage1 = p1; loadOffset = off; loadPageSel = sel;
    loadLength = LEN_W'(len); loadPos = pos; loadCount = cnt; loadLinkTerm = term;
    loadValid = 1'b1;
    @(negedge clk);
    loadValid = 1'b0;
  endtask

  task automatic takeSlice(input string tag, input logic [31:0] addr,
                           input int bytes, input logic [1:0] pos);
    chk({tag, " R8 valid"}, 32'(sliceValid), 32'd1);
    chk({tag, " R5 addr"}, sliceAddr, addr);
    chk({tag, " R4 bytes"}, 32'(sliceBytes), 32'(bytes));
    chk({tag, " R2 pos"}, 32'(slicePos), 32'(pos));
    sliceReady = 1'b1;
    @(negedge clk);
    sliceReady = 1'b0;
  endtask

  task automatic testReset;
    chk("R10 reset busy", 32'(busy), 0);
    chk("R10 reset valid", 32'(sliceValid), 0);
    chk("R10 reset done", 32'(done), 0);
    chk("R10 reset errors", 32'({errCount, errOverflow}), 0);
  endtask

  task automatic testSingle;
    doLoad(20'h12345, 20'h0, 12'h010, 1'b0, 100, 2'b00, 3'd1, 1'b0);
    takeSlice("R1 single", 32'h12345010, 100, 2'b00);
    chk("R1 R9 done", 32'(done), 1);
    chk("R9 link valid", 32'(backLinkValid), 1);
    chk("R8 valid low after", 32'(sliceValid), 0);
    @(negedge clk);
    chk("R9 done one cycle", 32'(done), 0);
    chk("R9 link gone", 32'(backLinkValid), 0);
  endtask

  task automatic testMulti;
    doLoad(20'h00ABC, 20'h0, 12'h100, 1'b0, 500, 2'b01, 3'd3, 1'b1);
    takeSlice("R2 first", 32'h00ABC100, 188, 2'b01);
    takeSlice("R2 R6 mid", 32'h00ABC1BC, 188, 2'b10);
    takeSlice("R2 R4 end", 32'h00ABC278, 124, 2'b11);
    chk("R9 done multi", 32'(done), 1);
    chk("R9 link terminated", 32'(backLinkValid), 0);
    @(negedge clk);
  endtask

  task automatic testFlipAndStall;
    doLoad(20'hAAAAA, 20'h55555, 12'hF80, 1'b0, 300, 2'b01, 3'd2, 1'b0);
    chk("R8 stall addr", sliceAddr, 32'hAAAAAF80);
    loadPage0 = 20'h11111; loadOffset = 12'h000; loadCount = 3'd1;
    loadLength = LEN_W'(5); loadPos = 2'b00; loadValid = 1'b1;
    @(negedge clk);
    @(negedge clk);
    loadValid = 1'b0;
    chk("R10 load ignored err", 32'(errCount), 0);
    takeSlice("R10 R8 held", 32'hAAAAAF80, 188, 2'b01);
    takeSlice("R6 flip end", 32'h5555503C, 112, 2'b11);
    chk("R6 done after flip", 32'(done), 1);
    @(negedge clk);
  endtask

  task automatic testExactBoundary;
    doLoad(20'h22222, 20'h33333, 12'hF44, 1'b0, 200, 2'b01, 3'd2, 1'b0);
    takeSlice("R6 exact", 32'h22222F44, 188, 2'b01);
    takeSlice("R6 wrap zero", 32'h33333000, 12, 2'b11);
    chk("R6 done", 32'(done), 1);
    @(negedge clk);
    doLoad(20'h0, 20'h44444, 12'hF44, 1'b1, 188, 2'b00, 3'd1, 1'b0);
    takeSlice("R7 page1 end exact", 32'h44444F44, 188, 2'b00);
    chk("R7 no overflow exact", 32'(errOverflow), 0);
    chk("R7 done exact", 32'(done), 1);
    @(negedge clk);
  endtask

  task automatic testOverflow;
    doLoad(20'h0, 20'h66666, 12'hF80, 1'b1, 300, 2'b01, 3'd2, 1'b0);
    takeSlice("R7 last page", 32'h66666F80, 188, 2'b01);
    chk("R7 overflow flag", 32'(errOverflow), 1);
    chk("R7 stopped", 32'(sliceValid), 0);
    chk("R7 no done", 32'(done), 0);
    @(negedge clk);
    chk("R7 still no done", 32'(done), 0);
  endtask

  task automatic testBadCount;
    doLoad(20'h1, 20'h2, 12'h0, 1'b0, 100, 2'b00, 3'd7, 1'b0);
    chk("R3 count7 err", 32'(errCount), 1);
    chk("R3 count7 no slice", 32'(sliceValid), 0);
    doLoad(20'h1, 20'h2, 12'h0, 1'b0, 100, 2'b00, 3'd0, 1'b0);
    chk("R3 count0 err", 32'(errCount), 1);
    chk("R3 count0 busy", 32'(busy), 0);
    doLoad(20'h00001, 20'h2, 12'h004, 1'b0, 10, 2'b00, 3'd1, 1'b0);
    chk("R3 err cleared", 32'(errCount), 0);
    takeSlice("R3 good after", 32'h00001004, 10, 2'b00);
    @(negedge clk);
  endtask

  task automatic testResetMid;
    doLoad(20'h7, 20'h8, 12'h0, 1'b0, 400, 2'b01, 3'd3, 1'b0);
    chk("R10 running", 32'(busy), 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10 reset mid busy", 32'(busy), 0);
    chk("R10 reset mid valid", 32'(sliceValid), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    testReset();
    testSingle();
    testMulti();
    testFlipAndStall();
    testExactBoundary();
    testOverflow();
    testBadCount();
    testResetMid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule